// File: doc/BRIEF.md
# SRAM Write-Then-Read Test Sequencer

This block exercises an asynchronous static RAM without help from software. After reset it walks the address range from zero up to a parameterised last address. At each location it writes a test word, which is the location's address plus a small seed taken from two switches. It advances through this write pass at the full clock rate. It then rewinds to address zero and reads every location back. Each read location is held for a programmable dwell time, so a person can follow the values on a two-digit seven-segment display.

The chip enable, output enable and lower-byte enable stay asserted for the whole run. The upper-byte enable stays deasserted, because only the low byte of the data bus carries test data. The write strobe is low for one clock per location, and the address and data are held steady around it. The sequencer releases the data bus in every cycle in which it is not writing. Two LEDs report that the write pass and the read pass have finished. After the read pass the sequencer parks until the next reset.

Top module: `sram_wr_rd_tester`

## Requirements
- R1: In each write cycle, the low DATA_W bits of the data bus carry the current address plus the 2-bit seed, computed modulo 2^DATA_W. The remaining upper bus bits are driven to zero.
- R2: The write pass takes two clocks per location. In the first clock the write strobe is low. In the second it is high and the address is unchanged. Addresses run 0, 1, … up to LAST_ADDR with no idle cycles.
- R3: The sequencer drives the data bus only in the clock in which the write strobe is low. In every other cycle the bus is left high-impedance.
- R4: The read pass starts at address 0 in the clock after the last write pair. Each location is presented for DWELL_CYC + 1 clocks before the address steps up by one.
- R5: The display holds the word captured at the end of each location's dwell. It shows two hexadecimal digits, with the high nibble in seg[13:7] and the low nibble in seg[6:0]. Each digit is active-high with segment a in bit 0 through segment g in bit 6, using the usual codes (0=3F, 1=06, … F=71). The display changes only when a new word is captured.
- R6: The write-done LED goes high in the first clock of the read pass and stays high until reset.
- R7: The read-done LED goes high after the last location's read. From then on the address stays at LAST_ADDR, the write strobe stays high and the read-done LED stays high.
- R8: Chip enable, output enable and lower-byte enable are held low, and the upper-byte enable is held high, at all times.
- R9: While reset is high, the address is 0, the write strobe is high, both LEDs are low and the display shows "00" (seg = 14'h1FBF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed | input | 2 | Offset added to each address to form the test word |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq | inout | BUS_W | Bidirectional memory data bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_lb_n | output | 1 | Lower-byte enable, active low |
| sram_ub_n | output | 1 | Upper-byte enable, active low |
| seg | output | 7*(DATA_W/4) | Segment lines for the hex digits, active high |
| wr_done_led | output | 1 | Write pass finished |
| rd_done_led | output | 1 | Read pass finished |

## Verification
The assertions assume that reset is applied at the start, so the sequencer begins in its first write step. They also assume that the seed stays constant during a pass; the stimulus changes it only while reset is high. The bench's memory model obeys the strobes. It latches the low byte while the write strobe is low, and it drives the bus whenever output enable is low and the write strobe is high. As a result, the only way the bus can become unknown is if the sequencer drives it outside its write cycle. The dwell is shortened through its parameter, and LAST_ADDR is set so that the largest test word carries into the upper hex digit.

// File: rtl/sramtest_pkg.sv
package sramtest_pkg;

  typedef enum logic [2:0] {
    ST_WR_SET,
    ST_WR_REL,
    ST_RD_WAIT,
    ST_RD_NEXT,
    ST_PARK
  } seq_state_e;

  // Hex nibble to active-high segments, bit 0 = a ... bit 6 = g.
  function automatic logic [6:0] hex_to_seg(input logic [3:0] v);
    logic [6:0] s;
    case (v)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_dwell_timer.sv
module sram_dwell_timer #(
  parameter int CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/sram_hex_display.sv
module sram_hex_display #(
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [DATA_W-1:0]       word,
  output logic [7*(DATA_W/4)-1:0] seg
);
  import sramtest_pkg::*;
  localparam int NDIG = DATA_W / 4;

  logic [DATA_W-1:0] shown_q;

  always_ff @(posedge clk) begin
    if (rst)       shown_q <= '0;
    else if (load) shown_q <= word;
  end

  for (genvar d = 0; d < NDIG; d++) begin : g_digit
    assign seg[7*d +: 7] = hex_to_seg(shown_q[4*d +: 4]);
  end

  assert_seg_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(seg));

endmodule

// File: rtl/sram_wr_rd_tester.sv
module sram_wr_rd_tester #(
  parameter int ADDR_W    = 4,
  parameter int LAST_ADDR = 2**ADDR_W - 1,
  parameter int DATA_W    = 8,
  parameter int BUS_W     = 16,
  parameter int DWELL_CYC = 25_000_000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              seed,
  output logic [ADDR_W-1:0]       sram_addr,
  inout  wire  [BUS_W-1:0]        sram_dq,
  output logic                    sram_ce_n,
  output logic                    sram_oe_n,
  output logic                    sram_we_n,
  output logic                    sram_lb_n,
  output logic                    sram_ub_n,
  output logic [7*(DATA_W/4)-1:0] seg,
  output logic                    wr_done_led,
  output logic                    rd_done_led
);
  import sramtest_pkg::*;

  localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(LAST_ADDR);

  function automatic logic [DATA_W-1:0] test_word(input logic [ADDR_W-1:0] a,
                                                   input logic [1:0] s);
    return DATA_W'(a) + DATA_W'(s);
  endfunction

  seq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_done_q, rd_done_q;

  // named internal events
  logic at_last, addr_step, addr_wrap, dwell_run, dwell_done, we_active, rd_finish;

  assign at_last   = (addr_q == END_ADDR);
  assign addr_step = ((st_q == ST_WR_REL) || (st_q == ST_RD_NEXT)) && !at_last;
  assign addr_wrap = (st_q == ST_WR_REL) && at_last;
  assign rd_finish = (st_q == ST_RD_NEXT) && at_last;
  assign dwell_run = (st_q == ST_RD_WAIT);
  assign we_active = (st_q == ST_WR_SET) && !rst;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_WR_SET:  st_d = ST_WR_REL;
      ST_WR_REL:  st_d = at_last ? ST_RD_WAIT : ST_WR_SET;
      ST_RD_WAIT: st_d = dwell_done ? ST_RD_NEXT : ST_RD_WAIT;
      ST_RD_NEXT: st_d = at_last ? ST_PARK : ST_RD_WAIT;
      default:    st_d = ST_PARK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_WR_SET;
      addr_q    <= '0;
      wr_done_q <= 1'b0;
      rd_done_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (addr_wrap)      addr_q <= '0;
      else if (addr_step) addr_q <= addr_q + 1'b1;
      if (addr_wrap) wr_done_q <= 1'b1;
      if (rd_finish) rd_done_q <= 1'b1;
    end
  end

  sram_dwell_timer #(.CYCLES(DWELL_CYC)) u_dwell (
    .clk    (clk),
    .rst    (rst),
    .run    (dwell_run),
    .expire (dwell_done)
  );

  sram_hex_display #(.DATA_W(DATA_W)) u_disp (
    .clk  (clk),
    .rst  (rst),
    .load (dwell_done),
    .word (sram_dq[DATA_W-1:0]),
    .seg  (seg)
  );

  assign sram_addr   = addr_q;
  assign sram_dq     = we_active ? BUS_W'(test_word(addr_q, seed)) : 'z;
  assign sram_we_n   = !we_active;
  assign sram_ce_n   = 1'b0;
  assign sram_oe_n   = 1'b0;
  assign sram_lb_n   = 1'b0;
  assign sram_ub_n   = 1'b1;
  assign wr_done_led = wr_done_q;
  assign rd_done_led = rd_done_q;

  assert_pair_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |=> (sram_we_n && $stable(sram_addr)));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    addr_step |=> (sram_addr == $past(sram_addr) + 1'b1));

  assert_single_capture_R4: assert property (@(posedge clk) disable iff (rst)
    dwell_done |=> !dwell_done);

  assert_wr_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    wr_done_led |=> wr_done_led);

  assert_rd_after_wr_R7: assert property (@(posedge clk) disable iff (rst)
    rd_done_led |-> wr_done_led);

  assert_park_R7: assert property (@(posedge clk) disable iff (rst)
    rd_done_led |=> (rd_done_led && sram_we_n && $stable(sram_addr)));

endmodule

// File: tb/sim_sram_wr_rd_tester.sv
module sim_sram_wr_rd_tester;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int LAST   = 13;
  localparam int DWELL  = 4;
  localparam int SEG_W  = 14;

  localparam logic [6:0] SEG_TAB [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
    7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] seed = 2'd0;
  logic [ADDR_W-1:0] sram_addr;
  wire  [15:0] sram_dq;
  logic sram_ce_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n;
  logic [SEG_W-1:0] seg;
  logic wr_done_led, rd_done_led;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_wr_rd_tester #(
    .ADDR_W(ADDR_W), .LAST_ADDR(LAST), .DATA_W(8), .BUS_W(16), .DWELL_CYC(DWELL)
  ) u0 (
    .clk(clk), .rst(rst), .seed(seed), .sram_addr(sram_addr), .sram_dq(sram_dq),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n), .seg(seg),
    .wr_done_led(wr_done_led), .rd_done_led(rd_done_led)
  );

  // behavioural asynchronous SRAM, low byte only
  logic [7:0] mem [16];
  initial for (int i = 0; i < 16; i++) mem[i] = 8'hEE;
  always @(sram_we_n or sram_addr or sram_dq or sram_ce_n or sram_lb_n)
    if (!sram_we_n && !sram_ce_n && !sram_lb_n) mem[sram_addr] = sram_dq[7:0];
  assign sram_dq = (!sram_ce_n && !sram_oe_n && sram_we_n) ? {8'hC3, mem[sram_addr]} : 16'hzzzz;

  typedef struct {
    int addr; bit we_n; bit wr; bit rd; int disp; bit drv;
  } exp_t;
  exp_t q[$];

  function automatic logic [13:0] segs_of(int v);
    return {SEG_TAB[(v >> 4) & 15], SEG_TAB[v & 15]};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic push(int a, bit w, bit wd, bit rd, int d, bit drv);
    exp_t e;
    e.addr = a; e.we_n = w; e.wr = wd; e.rd = rd; e.disp = d; e.drv = drv;
    q.push_back(e);
  endtask

  task automatic compare(exp_t e, int s);
    chk(sram_addr == ADDR_W'(e.addr), "R2/R4", "addr", sram_addr, e.addr);
    chk(sram_we_n == e.we_n, "R2", "we_n", sram_we_n, e.we_n);
    chk(wr_done_led == e.wr, "R6", "wr_done", wr_done_led, e.wr);
    chk(rd_done_led == e.rd, "R7", "rd_done", rd_done_led, e.rd);
    chk(seg == segs_of(e.disp), "R5", "seg", seg, segs_of(e.disp));
    chk({sram_ce_n, sram_oe_n, sram_lb_n, sram_ub_n} == 4'b0001, "R8", "strobes",
        {sram_ce_n, sram_oe_n, sram_lb_n, sram_ub_n}, 4'b0001);
    if (e.drv)
      chk(sram_dq === 16'((e.addr + s) & 255), "R1", "write data", sram_dq, (e.addr + s) & 255);
    else
      chk(!$isunknown(sram_dq), "R3", "bus contention", sram_dq, 0);
  endtask

  task automatic run_seed(int s);
    int disp = 0;
    exp_t e;
    q.delete();
    rst = 1'b1;
    seed = 2'(s);
    repeat (2) @(negedge clk);
    // R9: reset state
    chk(sram_addr == 0, "R9", "reset addr", sram_addr, 0);
    chk(sram_we_n == 1'b1, "R9", "reset we_n", sram_we_n, 1);
    chk(!wr_done_led && !rd_done_led, "R9", "reset leds", {wr_done_led, rd_done_led}, 0);
    chk(seg == 14'h1FBF, "R9", "reset seg", seg, 14'h1FBF);
    for (int a = 0; a <= LAST; a++) begin
      push(a, 1'b0, 1'b0, 1'b0, disp, 1'b1);
      push(a, 1'b1, 1'b0, 1'b0, disp, 1'b0);
    end
    for (int a = 0; a <= LAST; a++) begin
      for (int k = 0; k < DWELL; k++) push(a, 1'b1, 1'b1, 1'b0, disp, 1'b0);
      disp = (a + s) & 255;
      push(a, 1'b1, 1'b1, 1'b0, disp, 1'b0);
    end
    for (int k = 0; k < 10; k++) push(LAST, 1'b1, 1'b1, 1'b1, disp, 1'b0);
    rst = 1'b0;
    #1;
    e = q.pop_front();
    compare(e, s);
    while (q.size() > 0) begin
      @(negedge clk);
      e = q.pop_front();
      compare(e, s);
    end
    // R1: memory contents written by the write pass
    for (int a = 0; a <= LAST; a++)
      chk(mem[a] == 8'((a + s) & 255), "R1", "stored word", mem[a], (a + s) & 255);
  endtask

  initial begin
    run_seed(1);
    run_seed(3);
    run_seed(0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule